// File: doc/BRIEF.md
# Reloadable 8-bit Down-Counter Timer

This block is one timer channel. An 8-bit counter steps down by one on each clock cycle where the external count-enable input is high and the channel is running. When the counter is at zero and a count-enable pulse arrives, the channel signals an underflow for that cycle and loads the counter from an 8-bit reload register. Each underflow toggles an external output flop. A second flop toggles on every second underflow, which makes a divide-by-two clock for a serial interface.

Software uses a small synchronous register port. One address is a control word with three bits: a run/stop bit, a write-only preset strobe and an output-enable bit. A second address holds the reload value. A third address gives the live count, read-only. The preset strobe copies the reload value into the counter at once. If the channel is stopped, the counter keeps that value until it is started. When the output enable is off, the external output parks at 0 and the serial clock parks at 1.

The design has two state machines. The run machine has states ST_STOP and ST_RUN. The control write with bit 0 = 1 is transition GO (ST_STOP to ST_RUN). The control write with bit 0 = 0 is transition HALT (ST_RUN to ST_STOP). The output machine has states OUT_OFF and OUT_ON, with transitions ENABLE and DISABLE taken on control writes with bit 2 = 1 or 0. The counter has four actions per cycle: ACT_HOLD, ACT_DEC, ACT_WRAP (underflow with reload) and ACT_LOAD (preset). The serial divider has phases PH_EVEN and PH_ODD. Each underflow moves the divider to the other phase.

Top module: `tmr8_channel`

## Requirements
- R1: After reset, run = 0, output enable = 0, reload = 0 and count = 0. ext_out_o = 0, ser_clk_o = 1, and the control word reads 0.
- R2: While running, each cycle with cnt_en_i = 1 and a nonzero count lowers the count by 1 at the next clock edge. Cycles with cnt_en_i = 0 hold the count. A run write takes effect from the cycle after the write.
- R3: While stopped, the count holds whatever cnt_en_i does. Setting run again resumes from the held count, with no reload.
- R4: A control write with bit 1 = 1 loads the reload value into the counter at that edge. Bit 1 always reads 0. A control write with bit 1 = 0 leaves the count as it is.
- R5: After a preset while running, counting continues from the loaded value. After a preset while stopped, the loaded value is held until run is set.
- R6: When run = 1, cnt_en_i = 1 and the count is 0, uflow_o is high in that same cycle (combinational) and the counter takes the reload value at the edge. With reload = 0, every enabled cycle underflows.
- R7: While output enable = 0, ext_out_o = 0 and ser_clk_o = 1.
- R8: While output enable = 1, ext_out_o shows a flop that toggles at each underflow. ser_clk_o shows a flop that toggles at every second underflow, first at the second underflow after reset. Both flops keep tracking underflows while the outputs are parked.
- R9: When a preset write and an underflow condition fall in the same cycle, the preset wins. The counter loads the reload value, uflow_o stays 0 and neither output flop toggles.
- R10: Register map, with reg_rdata_o combinational from reg_addr_i.
  - Address 0 is control: bit 0 run, bit 1 preset, bit 2 output enable; other bits read 0.
  - Address 1 is reload, read/write.
  - Address 2 is the count, read-only.
  - Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Prescaled count-enable pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data at reg_addr_i |
| uflow_o | output | 1 | One-cycle underflow indication |
| ext_out_o | output | 1 | Gated underflow toggle output |
| ser_clk_o | output | 1 | Gated divide-by-two serial clock |

## Verification
uflow_o and reg_rdata_o are combinational, so they are due in the same cycle as the inputs that cause them. The bench drives inputs on the falling edge and samples these outputs 2 ns later. Count, register and output-flop changes land on the next rising edge, and they are compared at the following falling-edge sample. The bench updates its own model just after that rising edge, so each comparison uses exactly one edge of delay, as the design has. A run or stop write changes counting only from the cycle after the write.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;

    localparam int unsigned CB_RUN    = 0;
    localparam int unsigned CB_PRESET = 1;
    localparam int unsigned CB_OE     = 2;

    typedef enum logic {ST_STOP, ST_RUN} run_state_t;
    typedef enum logic {OUT_OFF, OUT_ON} out_state_t;
    typedef enum logic {PH_EVEN, PH_ODD} div_phase_t;
    typedef enum logic [1:0] {ACT_HOLD, ACT_DEC, ACT_WRAP, ACT_LOAD} cnt_act_t;
endpackage

// File: rtl/tmr8_ctrl_fsm.sv
module tmr8_ctrl_fsm
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl_i,
    input  logic run_bit_i,
    input  logic preset_bit_i,
    input  logic oe_bit_i,
    output logic run_o,
    output logic oe_o,
    output logic preset_o
);
    run_state_t run_q, run_d;
    out_state_t out_q, out_d;

    // next-state logic: GO / HALT and ENABLE / DISABLE
    always_comb begin
        run_d = run_q;
        out_d = out_q;
        if (wr_ctrl_i) begin
            unique case (run_q)
                ST_STOP: if (run_bit_i)  run_d = ST_RUN;
                ST_RUN:  if (!run_bit_i) run_d = ST_STOP;
            endcase
            unique case (out_q)
                OUT_OFF: if (oe_bit_i)  out_d = OUT_ON;
                OUT_ON:  if (!oe_bit_i) out_d = OUT_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= ST_STOP;
            out_q <= OUT_OFF;
        end else begin
            run_q <= run_d;
            out_q <= out_d;
        end
    end

    always_comb begin
        run_o    = (run_q == ST_RUN);
        oe_o     = (out_q == OUT_ON);
        preset_o = wr_ctrl_i && preset_bit_i;
    end
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             cnt_en_i,
    input  logic             preset_i,
    input  logic             rld_wr_i,
    input  logic [WIDTH-1:0] rld_wdata_i,
    output logic [WIDTH-1:0] count_o,
    output logic [WIDTH-1:0] reload_o,
    output logic             uflow_o
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] count_q, reload_q;
    cnt_act_t         act;

    // per-cycle action; a preset outranks an underflow
    always_comb begin
        if (preset_i)                act = ACT_LOAD;
        else if (run_i && cnt_en_i)  act = (count_q == ZERO) ? ACT_WRAP : ACT_DEC;
        else                         act = ACT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= ZERO;
        end else begin
            unique case (act)
                ACT_HOLD: count_q <= count_q;
                ACT_DEC:  count_q <= count_q - ONE;
                ACT_WRAP: count_q <= reload_q;
                ACT_LOAD: count_q <= reload_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        reload_q <= ZERO;
        else if (rld_wr_i) reload_q <= rld_wdata_i;
    end

    always_comb begin
        count_o  = count_q;
        reload_o = reload_q;
        uflow_o  = (act == ACT_WRAP);
    end
endmodule

// File: rtl/tmr8_clkout.sv
module tmr8_clkout
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic uflow_i,
    input  logic oe_i,
    output logic ext_q_o,
    output logic ext_out_o,
    output logic ser_clk_o
);
    logic       ext_q, ser_q;
    div_phase_t ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
            ser_q <= 1'b0;
            ph_q  <= PH_EVEN;
        end else if (uflow_i) begin
            ext_q <= ~ext_q;
            unique case (ph_q)
                PH_EVEN: ph_q <= PH_ODD;
                PH_ODD: begin
                    ph_q  <= PH_EVEN;
                    ser_q <= ~ser_q;
                end
            endcase
        end
    end

    // parked levels: external low, serial clock high
    always_comb begin
        ext_q_o   = ext_q;
        ext_out_o = oe_i ? ext_q : 1'b0;
        ser_clk_o = oe_i ? ser_q : 1'b1;
    end
endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel #(
    parameter int unsigned WIDTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cnt_en_i,
    input  logic                        reg_wr_i,
    input  logic [tmr8_pkg::ADDR_W-1:0] reg_addr_i,
    input  logic [WIDTH-1:0]            reg_wdata_i,
    output logic [WIDTH-1:0]            reg_rdata_o,
    output logic                        uflow_o,
    output logic                        ext_out_o,
    output logic                        ser_clk_o
);
    import tmr8_pkg::*;

    logic             wr_ctrl, wr_rld;
    logic             run_s, oe_s, preset_s, uflow_s, ext_q_s;
    logic [WIDTH-1:0] count_s, reload_s;

    assign wr_ctrl = reg_wr_i && (reg_addr_i == A_CTRL);
    assign wr_rld  = reg_wr_i && (reg_addr_i == A_RELOAD);

    tmr8_ctrl_fsm u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ctrl_i    (wr_ctrl),
        .run_bit_i    (reg_wdata_i[CB_RUN]),
        .preset_bit_i (reg_wdata_i[CB_PRESET]),
        .oe_bit_i     (reg_wdata_i[CB_OE]),
        .run_o        (run_s),
        .oe_o         (oe_s),
        .preset_o     (preset_s)
    );

    tmr8_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_s),
        .cnt_en_i    (cnt_en_i),
        .preset_i    (preset_s),
        .rld_wr_i    (wr_rld),
        .rld_wdata_i (reg_wdata_i),
        .count_o     (count_s),
        .reload_o    (reload_s),
        .uflow_o     (uflow_s)
    );

    tmr8_clkout u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .uflow_i   (uflow_s),
        .oe_i      (oe_s),
        .ext_q_o   (ext_q_s),
        .ext_out_o (ext_out_o),
        .ser_clk_o (ser_clk_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_CTRL: begin
                reg_rdata_o[CB_RUN] = run_s;
                reg_rdata_o[CB_OE]  = oe_s;
            end
            A_RELOAD: reg_rdata_o = reload_s;
            A_COUNT:  reg_rdata_o = count_s;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign uflow_o = uflow_s;
endmodule

// File: rtl/tmr8_checker.sv
module tmr8_checker
    import tmr8_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cnt_en,
    input logic                 preset,
    input logic                 run,
    input logic                 oe,
    input logic [WIDTH-1:0]     count,
    input logic [WIDTH-1:0]     reload,
    input logic                 uflow,
    input logic                 ext_q,
    input logic                 ext_out,
    input logic                 ser_clk,
    input logic [ADDR_W-1:0]    addr,
    input logic [WIDTH-1:0]     rdata
);
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_en && !preset && count != '0) |=> (count == $past(count) - WIDTH'(1)));

    assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !preset) |=> $stable(count));

    assert_preset_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (count == $past(reload)));

    assert_uflow_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> (count == $past(reload)));

    assert_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!ext_out && ser_clk));

    assert_ext_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> (ext_q != $past(ext_q)));

    assert_preset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        preset |-> !uflow);

    assert_preset_reads0_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> !rdata[CB_PRESET]);
endmodule

bind tmr8_channel tmr8_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en_i),
    .preset  (preset_s),
    .run     (run_s),
    .oe      (oe_s),
    .count   (count_s),
    .reload  (reload_s),
    .uflow   (uflow_s),
    .ext_q   (ext_q_s),
    .ext_out (ext_out_o),
    .ser_clk (ser_clk_o),
    .addr    (reg_addr_i),
    .rdata   (reg_rdata_o)
);

// File: tb/tmr8_channel_tb.sv
module tmr8_channel_tb;
    import tmr8_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [1:0] reg_addr_i = 2'd0;
    logic [7:0] reg_wdata_i = 8'd0;
    logic [7:0] reg_rdata_o;
    logic       uflow_o, ext_out_o, ser_clk_o;

    always #10 clk = ~clk;

    tmr8_channel #(.WIDTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .uflow_o(uflow_o), .ext_out_o(ext_out_o), .ser_clk_o(ser_clk_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference state built from the requirements
    logic       m_run = 0, m_oe = 0, m_ext = 0, m_ph = 0, m_ser = 0;
    logic [7:0] m_rld = 0, m_cnt = 0;

    function automatic logic [7:0] exp_rdata(logic [1:0] a);
        case (a)
            2'd0:    return {5'd0, m_oe, 1'b0, m_run};
            2'd1:    return m_rld;
            2'd2:    return m_cnt;
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic exp_preset(logic wr, logic [1:0] a, logic [7:0] d);
        return wr && (a == 2'd0) && d[1];
    endfunction

    function automatic logic exp_uflow(logic en, logic wr, logic [1:0] a, logic [7:0] d);
        return m_run && en && (m_cnt == 8'd0) && !exp_preset(wr, a, d);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic en, input logic wr, input logic [1:0] a,
                       input logic [7:0] d, input string req);
        logic uf, pre;
        @(negedge clk);
        cnt_en_i = en; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
        #2;
        uf  = exp_uflow(en, wr, a, d);
        pre = exp_preset(wr, a, d);
        chk(req, "uflow_o", int'(uflow_o), int'(uf));
        chk(req, "ext_out_o", int'(ext_out_o), int'(m_oe ? m_ext : 1'b0));
        chk(req, "ser_clk_o", int'(ser_clk_o), int'(m_oe ? m_ser : 1'b1));
        chk(req, "reg_rdata_o", int'(reg_rdata_o), int'(exp_rdata(a)));
        @(posedge clk);
        #1;
        if (pre)                m_cnt = m_rld;
        else if (m_run && en)   m_cnt = (m_cnt == 8'd0) ? m_rld : m_cnt - 8'd1;
        if (uf) begin
            m_ext = ~m_ext;
            if (m_ph) m_ser = ~m_ser;
            m_ph = ~m_ph;
        end
        if (wr && a == 2'd0) begin m_run = d[0]; m_oe = d[2]; end
        if (wr && a == 2'd1) m_rld = d;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] d;
        logic [1:0] a;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset values at the ports
        chk("R1", "ext_out_o", int'(ext_out_o), 0);
        chk("R1", "ser_clk_o", int'(ser_clk_o), 1);
        chk("R1", "ctrl", int'(reg_rdata_o), 0);
        cyc(0, 0, A_RELOAD, 8'h00, "R1");
        cyc(0, 0, A_COUNT, 8'h00, "R1");
        // R10: map and unused bits
        cyc(0, 1, A_RELOAD, 8'd3, "R10");
        cyc(0, 0, A_RELOAD, 8'd0, "R10");
        cyc(0, 1, A_CTRL, 8'hF8, "R10");
        cyc(0, 0, A_CTRL, 8'd0, "R10");
        cyc(0, 1, 2'd3, 8'h55, "R10");
        cyc(0, 0, 2'd3, 8'd0, "R10");
        // R4: preset while stopped, zero write does nothing
        cyc(0, 1, A_CTRL, 8'h02, "R4");
        cyc(0, 0, A_COUNT, 8'd0, "R4");
        chk("R4", "count after preset", int'(reg_rdata_o), 3);
        cyc(0, 1, A_RELOAD, 8'd9, "R4");
        cyc(0, 1, A_CTRL, 8'h00, "R4");
        cyc(0, 0, A_COUNT, 8'd0, "R4");
        chk("R4", "count unchanged", int'(reg_rdata_o), 3);
        // R5: stopped count holds the preset value
        for (int i = 0; i < 3; i++) cyc(1, 0, A_COUNT, 8'd0, "R5");
        chk("R5", "held preset", int'(reg_rdata_o), 3);
        cyc(0, 1, A_RELOAD, 8'd3, "R5");
        // R2 / R6 / R8: run with outputs on
        cyc(0, 1, A_CTRL, 8'h05, "R2");
        for (int i = 0; i < 6; i++) cyc(i[0], 0, A_COUNT, 8'd0, "R2");
        for (int i = 0; i < 14; i++) cyc(1, 0, A_COUNT, 8'd0, "R8");
        // R3: stop, hold, resume without reload
        cyc(1, 1, A_CTRL, 8'h04, "R3");
        for (int i = 0; i < 4; i++) cyc(1, 0, A_COUNT, 8'd0, "R3");
        cyc(1, 1, A_CTRL, 8'h05, "R3");
        for (int i = 0; i < 5; i++) cyc(1, 0, A_COUNT, 8'd0, "R3");
        // R5: preset while running
        cyc(1, 1, A_RELOAD, 8'd6, "R5");
        cyc(1, 1, A_CTRL, 8'h07, "R5");
        for (int i = 0; i < 4; i++) cyc(1, 0, A_COUNT, 8'd0, "R5");
        // R6: reload 0 gives an underflow every enabled cycle
        cyc(0, 1, A_RELOAD, 8'd0, "R6");
        for (int i = 0; i < 10; i++) cyc(1, 0, A_COUNT, 8'd0, "R6");
        // R9: preset and underflow together
        cyc(1, 1, A_CTRL, 8'h07, "R9");
        chk("R9", "preset wins", int'(uflow_o), 0);
        cyc(1, 0, A_COUNT, 8'd0, "R9");
        // R7: outputs parked while running
        cyc(1, 1, A_CTRL, 8'h01, "R7");
        for (int i = 0; i < 6; i++) cyc(1, 0, A_CTRL, 8'd0, "R7");
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            if (a == A_RELOAD) d = d & 8'h07;
            if (a == A_CTRL && ($urandom_range(0, 3) != 0)) d[0] = 1'b1;
            cyc(($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0), a, d, "R2");
        end
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule